// File: doc/BRIEF.md
# Three-Source Divided Clock Selector

This block builds a set of divided clock outputs from three source clocks. The sources are modelled as single-cycle tick strobes in one system clock domain. Each output has three divider fields, one for each source. A 2-bit select code picks which divided source drives the output. The fourth select code parks the output, so the select field is also the output gate. Each output is a one-cycle pulse, sent once per divided period of the selected source.

Software-style register access uses a simple write strobe and a combinational read port. The select codes of all outputs are packed into a 64-bit pair of words, starting at a configurable bit position. The divider values are stored as one word per output and per source. For each source there is a status word, and a bit in it reports that an output has completed a full divided period on that source since its select last changed.

Changing the select restarts the output on the new source. Changing a divider value takes effect only when the current period ends, so a period is never cut short.

Top module: `clksel_top`

## Requirements
- R1: After reset every select field reads 3 (off), every divider field reads 0, every status word reads 0 and no output pulse appears, whatever the source ticks do.
- R2: The 2-bit select code of output o lies at bit position p = SEL_LSB + 2*o of a 64-bit field pair. The low word is at address 0x000 and the high word at 0x004, so p >= 32 lands in the high word at bit p-32. With the defaults, outputs 0 and 1 sit at low-word bits 29:28 and 31:30, and outputs 2 and 3 at high-word bits 1:0 and 3:2. Unused bits read 0.
- R3: The divider value of output o for source k (k = 0, 1, 2) is bits 4:0 of the word at address 0x100*(k+1) + 4*o. The upper bits of that word read 0, and a write changes only that one field.
- R4: With select code k (0, 1 or 2) and divider value N, an output gives exactly one one-cycle pulse for every N+1 ticks of source k. The pulse comes in the cycle after the tick that ends the period. Ticks of the other two sources have no effect.
- R5: With select code 3 an output gives no pulses and all of its status bits read 0.
- R6: The status word of source k is at address 0x010 + 4*k. Its bit FB_LSB + o reads 1 only while output o is selected to source k and has completed at least one period there. The same bit reads 0 in the status words of the other sources.
- R7: A change of the select code restarts the output in the following cycle: the divider count clears, the status bit drops, and the divider value for the new source is loaded. The first pulse and the status bit then both rise after N+1 ticks of the new source.
- R8: A divider write made in the middle of a period does not shorten or lengthen that period. The new value governs the periods that follow the next period end.
- R9: When a select write lands in the same cycle as a tick of the old source, that tick still counts on the old source and can end its period. A tick in the next cycle, the restart cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick_i | input | 3 | One-cycle tick strobes of the three sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| clk_pulse_o | output | NUM_OUT | One pulse per divided period, one bit per output |

## Verification
Two pairs of events can fall in the same cycle. A register write can coincide with a source tick at the edge where the divider state moves. A select write can coincide with a tick of the old source, and a divider write can coincide with a tick partway through a period. The bench drives both combinations in the same cycle. It then judges the pulse count against R9: the old tick completes its period and the restart-cycle tick is dropped. It judges R8 the same way: the old period length holds and the new value applies from the next period onward.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NUM_SRC        = 3;
  localparam int SEL_W          = 2;
  localparam int DIV_W          = 5;
  localparam int REG_W          = 32;
  localparam int ADDR_SEL_LO    = 'h000;
  localparam int ADDR_SEL_HI    = 'h004;
  localparam int ADDR_FB_BASE   = 'h010;
  localparam int DIV_PAGE_SHIFT = 8;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [DIV_W-1:0] div_t;

  localparam sel_t SEL_OFF = 2'd3;
endpackage

// File: rtl/clksel_rst_sync.sv
module clksel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SEL_LSB = 28,
  parameter int FB_LSB  = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      we_i,
  input  logic [ADDR_W-1:0]                         addr_i,
  input  logic [REG_W-1:0]                          wdata_i,
  output logic [REG_W-1:0]                          rdata_o,
  output logic [NUM_OUT-1:0][SEL_W-1:0]             sel_o,
  output logic [NUM_OUT-1:0][NUM_SRC-1:0][DIV_W-1:0] div_o,
  input  logic [NUM_OUT-1:0][NUM_SRC-1:0]           run_i
);
  localparam int PAGE_W = ADDR_W - DIV_PAGE_SHIFT;
  localparam int SLOT_W = DIV_PAGE_SHIFT - 2;

  logic [NUM_OUT-1:0][SEL_W-1:0]              sel_q, sel_d;
  logic [NUM_OUT-1:0][NUM_SRC-1:0][DIV_W-1:0] div_q, div_d;
  logic                                       hit_lo, hit_hi;
  logic [NUM_SRC-1:0]                         hit_fb, hit_div;
  logic [PAGE_W-1:0]                          page;
  logic [SLOT_W-1:0]                          slot;
  logic [2*REG_W-1:0]                         sel_flat;
  logic [NUM_SRC-1:0][REG_W-1:0]              fb_word;

  assign page   = addr_i[ADDR_W-1:DIV_PAGE_SHIFT];
  assign slot   = addr_i[DIV_PAGE_SHIFT-1:2];
  assign hit_lo = (addr_i == ADDR_W'(ADDR_SEL_LO));
  assign hit_hi = (addr_i == ADDR_W'(ADDR_SEL_HI));

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      hit_fb[k]  = (addr_i == ADDR_W'(ADDR_FB_BASE + 4*k));
      hit_div[k] = (page == PAGE_W'(k+1)) && (addr_i[1:0] == 2'b00);
    end
  end

  // next-state for the select fields and divider words
  always_comb begin
    sel_d = sel_q;
    div_d = div_q;
    for (int o = 0; o < NUM_OUT; o++) begin
      if (hit_lo && (SEL_LSB + 2*o) < REG_W)
        sel_d[o] = sel_t'(wdata_i >> ((SEL_LSB + 2*o) % REG_W));
      if (hit_hi && (SEL_LSB + 2*o) >= REG_W)
        sel_d[o] = sel_t'(wdata_i >> ((SEL_LSB + 2*o) % REG_W));
      for (int k = 0; k < NUM_SRC; k++)
        if (hit_div[k] && slot == SLOT_W'(o))
          div_d[o][k] = wdata_i[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= {NUM_OUT{SEL_OFF}};
      div_q <= '0;
    end else if (we_i) begin
      sel_q <= sel_d;
      div_q <= div_d;
    end
  end

  // read path
  always_comb begin
    sel_flat = '0;
    fb_word  = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      sel_flat[SEL_LSB + 2*o +: SEL_W] = sel_q[o];
      for (int k = 0; k < NUM_SRC; k++)
        fb_word[k][FB_LSB + o] = run_i[o][k];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_lo) rdata_o = sel_flat[REG_W-1:0];
    if (hit_hi) rdata_o = sel_flat[2*REG_W-1:REG_W];
    for (int k = 0; k < NUM_SRC; k++) begin
      if (hit_fb[k]) rdata_o = fb_word[k];
      for (int o = 0; o < NUM_OUT; o++)
        if (hit_div[k] && slot == SLOT_W'(o))
          rdata_o = REG_W'(div_q[o][k]);
    end
  end

  assign sel_o = sel_q;
  assign div_o = div_q;
endmodule

// File: rtl/clksel_chan.sv
module clksel_chan
  import clksel_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [NUM_SRC-1:0][DIV_W-1:0] div_i,
  input  logic [NUM_SRC-1:0]            src_i,
  output logic                          pulse_o,
  output logic [NUM_SRC-1:0]            run_o
);
  sel_t sel_seen_q, sel_seen_d;
  div_t cnt_q, cnt_d, act_q, act_d, div_sel;
  logic run_q, run_d, pulse_q, pulse_d, src_hit;

  always_comb begin
    div_sel = '0;
    src_hit = 1'b0;
    for (int k = 0; k < NUM_SRC; k++)
      if (sel_i == sel_t'(k)) begin
        div_sel = div_i[k];
        src_hit = src_i[k];
      end
  end

  always_comb begin
    sel_seen_d = sel_i;
    cnt_d      = cnt_q;
    act_d      = act_q;
    run_d      = run_q;
    pulse_d    = 1'b0;
    if (sel_i != sel_seen_q) begin
      cnt_d = '0;
      act_d = div_sel;
      run_d = 1'b0;
    end else if (src_hit) begin
      if (cnt_q == act_q) begin
        cnt_d   = '0;
        act_d   = div_sel;
        pulse_d = 1'b1;
        run_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_seen_q <= SEL_OFF;
      cnt_q      <= '0;
      act_q      <= '0;
      run_q      <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      sel_seen_q <= sel_seen_d;
      cnt_q      <= cnt_d;
      act_q      <= act_d;
      run_q      <= run_d;
      pulse_q    <= pulse_d;
    end
  end

  always_comb
    for (int k = 0; k < NUM_SRC; k++)
      run_o[k] = run_q && (sel_seen_q == sel_t'(k));

  assign pulse_o = pulse_q;

  // R4: a pulse is always preceded by a tick of the selected source
  a_r4_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(src_hit));

  // R5: parked channel stays silent and not running
  a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_seen_q == SEL_OFF) |-> (!run_q && !pulse_q));

  // R7: a select change restarts the channel in the next cycle
  a_r7_switch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i != sel_seen_q) |=> (!run_q && !pulse_q && cnt_q == '0));

  // R7: running only rises together with a completed period
  a_r7_run_rises_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> pulse_q);

  // R8: the count never passes the latched period length
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q);
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SEL_LSB = 28,
  parameter int FB_LSB  = 4,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [2:0]         src_tick_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [NUM_OUT-1:0] clk_pulse_o
);
  logic                                       rst_n;
  logic [NUM_OUT-1:0][SEL_W-1:0]              sel;
  logic [NUM_OUT-1:0][NUM_SRC-1:0][DIV_W-1:0] div;
  logic [NUM_OUT-1:0][NUM_SRC-1:0]            run;

  clksel_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  clksel_regs #(
    .NUM_OUT (NUM_OUT),
    .SEL_LSB (SEL_LSB),
    .FB_LSB  (FB_LSB),
    .ADDR_W  (ADDR_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .sel_o   (sel),
    .div_o   (div),
    .run_i   (run)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chan
    clksel_chan chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (sel[o]),
      .div_i   (div[o]),
      .src_i   (src_tick_i),
      .pulse_o (clk_pulse_o[o]),
      .run_o   (run[o])
    );
  end
endmodule

// File: tb/clksel_top_tb_top.sv
`timescale 1ns/1ps
module clksel_top_tb_top;
  localparam int NUM_OUT = 4;
  localparam int SEL_LSB = 28;
  localparam int FB_LSB  = 4;

  logic               clk = 1'b0;
  logic               arst_n = 1'b0;
  logic [2:0]         src;
  logic               we;
  logic [11:0]        addr;
  logic [31:0]        wdata;
  logic [31:0]        rdata;
  logic [NUM_OUT-1:0] pulse;

  int pcnt [NUM_OUT] = '{default: 0};
  int checks = 0;
  int errs = 0;
  logic [1:0] exp_sel [NUM_OUT];

  always #2.5 clk = ~clk;

  clksel_top #(.NUM_OUT(NUM_OUT), .SEL_LSB(SEL_LSB), .FB_LSB(FB_LSB), .ADDR_W(12)) dut_i (
    .clk(clk), .arst_n(arst_n), .src_tick_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .clk_pulse_o(pulse)
  );

  always @(negedge clk)
    for (int o = 0; o < NUM_OUT; o++)
      if (pulse[o] === 1'b1) pcnt[o] = pcnt[o] + 1;

  function automatic logic [11:0] div_addr(int k, int o);
    return 12'(256*(k+1) + 4*o);
  endfunction

  function automatic logic [11:0] fb_addr(int k);
    return 12'(16 + 4*k);
  endfunction

  function automatic logic [31:0] sel_word(int w);
    logic [63:0] flat = '0;
    for (int o = 0; o < NUM_OUT; o++) flat[SEL_LSB + 2*o +: 2] = exp_sel[o];
    return (w != 0) ? flat[63:32] : flat[31:0];
  endfunction

  task automatic cyc(input logic [2:0] s, input logic w, input logic [11:0] a, input logic [31:0] d);
    src = s; we = w; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'b000, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(3'b000, 1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    src = 3'b000; we = 1'b0; addr = a;
    #1 v = rdata;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_sel(input int o, input logic [1:0] code);
    int w;
    exp_sel[o] = code;
    w = ((SEL_LSB + 2*o) >= 32) ? 1 : 0;
    wr((w != 0) ? 12'h004 : 12'h000, sel_word(w));
  endtask

  task automatic ticks(input logic [2:0] s, input int n);
    for (int i = 0; i < n; i++) cyc(s, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b;
    void'($urandom(32'h5EED_C10C));
    src = '0; we = 1'b0; addr = '0; wdata = '0;
    for (int o = 0; o < NUM_OUT; o++) exp_sel[o] = 2'd3;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(12'h000, v); chk("R1 sel low word", v, 32'hF000_0000);
    rd(12'h004, v); chk("R1 sel high word", v, 32'h0000_000F);
    for (int k = 0; k < 3; k++) begin
      rd(fb_addr(k), v); chk("R1 status word", v, 32'h0);
      rd(div_addr(k, 3), v); chk("R1 divider word", v, 32'h0);
    end
    ticks(3'b111, 20); idle(2);
    for (int o = 0; o < NUM_OUT; o++) chk("R1 no pulses", pcnt[o], 0);

    // R2: packing and spill into the high word
    for (int o = 0; o < NUM_OUT; o++) set_sel(o, 2'($urandom % 4));
    rd(12'h000, v); chk("R2 random low word", v, sel_word(0));
    rd(12'h004, v); chk("R2 random high word", v, sel_word(1));
    set_sel(2, 2'd1);
    rd(12'h004, v); chk("R2 out2 at high bits 1:0", v & 32'h3, 32'h1);
    for (int o = 0; o < NUM_OUT; o++) set_sel(o, 2'd3);
    rd(12'h000, v); chk("R2 all off low", v, 32'hF000_0000);

    // R3: divider words
    wr(div_addr(2, 3), 32'hFFFF_FFE7);
    rd(div_addr(2, 3), v); chk("R3 upper bits zero", v, 32'h7);
    wr(div_addr(0, 1), 32'h1F);
    rd(div_addr(0, 1), v); chk("R3 full field", v, 32'h1F);
    rd(div_addr(0, 2), v); chk("R3 neighbour untouched", v, 32'h0);
    rd(div_addr(1, 1), v); chk("R3 other source untouched", v, 32'h0);

    // R7: first period after a select change
    wr(div_addr(0, 0), 32'd4);
    set_sel(0, 2'd0); idle(1);
    b = pcnt[0];
    ticks(3'b001, 4); idle(2);
    chk("R7 no pulse before N+1 ticks", pcnt[0] - b, 0);
    rd(fb_addr(0), v); chk("R7 status low before first period", v, 32'h0);
    ticks(3'b001, 1); idle(2);
    chk("R7 first pulse after N+1 ticks", pcnt[0] - b, 1);
    rd(fb_addr(0), v); chk("R6 status bit for source 0", v, 32'(1) << FB_LSB);
    rd(fb_addr(1), v); chk("R6 other source status clear", v, 32'h0);

    // R7: switch while running drops status at once
    wr(div_addr(1, 0), 32'd0);
    set_sel(0, 2'd1); idle(1);
    rd(fb_addr(0), v); chk("R7 old status dropped", v, 32'h0);
    rd(fb_addr(1), v); chk("R7 new status not yet up", v, 32'h0);
    b = pcnt[0];
    ticks(3'b010, 1); idle(2);
    chk("R7 pulse on new source", pcnt[0] - b, 1);
    rd(fb_addr(1), v); chk("R6 status follows new source", v, 32'(1) << FB_LSB);

    // R9: select write coincident with an old-source tick
    b = pcnt[0];
    ticks(3'b010, 2);
    exp_sel[0] = 2'd0;
    cyc(3'b011, 1'b1, 12'h000, sel_word(0));
    cyc(3'b011, 1'b0, 12'h000, 32'h0);
    idle(2);
    chk("R9 old tick completes, restart tick ignored", pcnt[0] - b, 3);
    set_sel(0, 2'd3);

    // R8: divider write mid-period, coincident with a tick
    wr(div_addr(0, 2), 32'd3);
    set_sel(2, 2'd0); idle(1);
    b = pcnt[2];
    ticks(3'b001, 2);
    cyc(3'b001, 1'b1, div_addr(0, 2), 32'd1);
    ticks(3'b001, 1); idle(2);
    chk("R8 current period keeps old length", pcnt[2] - b, 1);
    ticks(3'b001, 4); idle(2);
    chk("R8 new length after boundary", pcnt[2] - b, 3);
    set_sel(2, 2'd3);

    // R5: off code silences output
    wr(div_addr(2, 1), 32'd0);
    set_sel(1, 2'd2); idle(1);
    b = pcnt[1];
    ticks(3'b100, 5); idle(2);
    chk("R4 divide by one", pcnt[1] - b, 5);
    rd(fb_addr(2), v); chk("R6 status for output 1", v, 32'(1) << (FB_LSB + 1));
    set_sel(1, 2'd3); idle(1);
    b = pcnt[1];
    ticks(3'b111, 30); idle(2);
    chk("R5 no pulses when off", pcnt[1] - b, 0);
    rd(fb_addr(2), v); chk("R5 status clear when off", v, 32'h0);

    // R4 / R6: random settings
    for (int it = 0; it < 16; it++) begin
      int o, k, n, t;
      logic [2:0] s;
      o = int'($urandom % NUM_OUT);
      k = int'($urandom % 3);
      n = (it == 3) ? 31 : int'($urandom % 6);
      wr(div_addr(k, o), 32'(n));
      set_sel(o, 2'(k)); idle(1);
      b = pcnt[o];
      t = 0;
      for (int i = 0; i < 120; i++) begin
        s = 3'($urandom);
        if (s[k]) t++;
        cyc(s, 1'b0, 12'h0, 32'h0);
      end
      idle(2);
      chk("R4 pulse count", pcnt[o] - b, t / (n + 1));
      for (int j = 0; j < 3; j++) begin
        rd(fb_addr(j), v);
        chk("R6 status word", v, (j == k && t >= n + 1) ? (32'(1) << (FB_LSB + o)) : 32'h0);
      end
      set_sel(o, 2'd3);
    end

    summary();
    $finish;
  end
endmodule